// File: doc/BRIEF.md
# Serial Memory Page-Write Buffer Engine

This block collects one write transfer for a small byte-addressed non-volatile array and commits it as a single internal write cycle. A serial front-end hands it a starting word address, then zero or more data bytes, and finally either a Stop (commit) or an abort (discard). Bytes are staged in a page buffer that covers one aligned page. Each incoming byte lands at the current slot, and only the slot index advances, so a long transfer wraps inside the page and never spills into the next one. Each slot carries a valid mask bit.

On Stop the engine raises busy for a programmable number of clock cycles. In the first page-size cycles of that window it walks the slots in ascending order and drives the array write port for every slot that received a byte. Pages in the upper half of the address space are permanently read-only. A transfer aimed at them still fills the buffer and still produces a full busy window, but no write strobe reaches the array. While busy, every input is ignored.

Top module: `pgwr_engine`

## Requirements
- R1: A pulse on `addr_load` sets the page (address bits 7:3) and the slot (bits 2:0). Each accepted data byte is stored at the current slot, and the slot then advances by one modulo 8 while the page bits stay fixed.
- R2: When more than 8 bytes arrive before Stop, the slot wraps to the page start, and the later bytes replace the earlier ones at the same slots.
- R3: `mem_we` is never high outside the busy window, so the array is untouched until Stop. A Stop with no byte buffered ends the transfer without a busy window.
- R4: At commit, only slots that received a byte are written. A single-byte transfer writes exactly one location. Every other byte of the page keeps its old value.
- R5: `mem_we` is never high for an address with bit 7 set (80h-FFh). Addresses 00h-7Fh are written normally, including the page at 78h-7Fh.
- R6: `busy` rises in the cycle after the clock edge that samples Stop and stays high for exactly `WRITE_CYCLES` cycles. Writes are issued during its first 8 cycles, in ascending slot order.
- R7: While `busy` is high, `addr_load`, `data_valid`, `stop` and `abort` have no effect. A Stop seen outside a transfer is also ignored.
- R8: An `abort`, or a new `addr_load` during a transfer, discards all buffered bytes. An abort leaves the array unchanged and raises no busy window. A new load starts a fresh transfer at the new address.
- R9: After reset, `busy` and `mem_we` are low and the buffer is empty.
- R10: A transfer into the protected half still raises `busy` for the full `WRITE_CYCLES` cycles after Stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Start a transfer at `addr_in` |
| addr_in | input | 8 | Starting word address |
| data_valid | input | 1 | One data byte on `data_in` |
| data_in | input | 8 | Data byte |
| stop | input | 1 | End the transfer and commit |
| abort | input | 1 | End the transfer and discard |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two kinds of internal fault show at the ports in different ways. A wrong slot pointer or a stale valid bit appears only after Stop, as a wrong byte or a missing byte in the array. The bench therefore compares the whole array with a model after every busy window ends. A fault in the protect decision or in the busy counter shows within the same window, as a strobe at an upper-half address or as a busy count different from `WRITE_CYCLES`. A fault in the ignore-while-busy gating appears at the next commit, or as a second busy window. That is why the bench probes straight after the window with a lone Stop.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_BUSY = 2'd2
   } pgwr_state_e;
endpackage

// File: rtl/pgwr_ptr.sv
module pgwr_ptr #(
   parameter int ADDR_W = 8,
   parameter int SLOT_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [ADDR_W-1:0]        load_addr,
   input  logic                     step,
   output logic [ADDR_W-SLOT_W-1:0] page_o,
   output logic [SLOT_W-1:0]        slot_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_o <= '0;
         slot_o <= '0;
      end else if (load) begin
         page_o <= load_addr[ADDR_W-1:SLOT_W];
         slot_o <= load_addr[SLOT_W-1:0];
      end else if (step) begin
         slot_o <= slot_o + 1'b1;
      end
   end

   // R1
   step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (page_o == $past(page_o)) &&
                          (slot_o == SLOT_W'($past(slot_o) + 1'b1)));
endmodule

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              any_valid
);
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DEPTH-1:0]  vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (clear) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_slot] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !clear) begin
         mem_q[wr_slot] <= wr_data;
      end
   end

   assign rd_data   = mem_q[rd_slot];
   assign rd_valid  = vld_q[rd_slot];
   assign any_valid = |vld_q;

   // R8
   clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !any_valid);
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
   parameter int WRITE_CYCLES = 16,
   parameter int CNT_W        = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             last,
   output logic [CNT_W-1:0] cnt
);
   assign last = busy && (cnt == CNT_W'(WRITE_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         busy <= start;
         cnt  <= '0;
      end else if (last) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R6
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt < CNT_W'(WRITE_CYCLES)));
endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine #(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 8,
   parameter int PAGE_BYTES    = 8,
   parameter int WRITE_CYCLES  = 16,
   parameter bit PROTECT_UPPER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              data_valid,
   input  logic [DATA_W-1:0] data_in,
   input  logic              stop,
   input  logic              abort,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy
);
   import pgwr_pkg::*;

   localparam int SLOT_W = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - SLOT_W;
   localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

   if (PAGE_BYTES < 2 || (1 << SLOT_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two, at least 2");
   end
   if (ADDR_W <= SLOT_W) begin : g_bad_addr
      $error("ADDR_W must exceed the slot width");
   end
   if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_time
      $error("WRITE_CYCLES must cover one cycle per page slot");
   end

   pgwr_state_e        state_q;
   logic [PAGE_W-1:0]  page;
   logic [SLOT_W-1:0]  slot;
   logic [CNT_W-1:0]   tcnt;
   logic               t_last, t_start;
   logic               in_fill, do_load, do_data, do_clear;
   logic               any_vld, rd_vld, commit_slot, protect;
   logic [SLOT_W-1:0]  rd_slot;

   assign in_fill  = (state_q == ST_FILL);
   assign do_load  = (state_q != ST_BUSY) && addr_load && !(in_fill && (abort || stop));
   assign do_data  = in_fill && data_valid && !addr_load && !abort && !stop;
   assign t_start  = in_fill && stop && !abort && any_vld;
   assign do_clear = do_load || (in_fill && (abort || (stop && !any_vld))) || t_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (addr_load) state_q <= ST_FILL;
            ST_FILL: begin
               if (abort)       state_q <= ST_IDLE;
               else if (stop)   state_q <= any_vld ? ST_BUSY : ST_IDLE;
            end
            ST_BUSY: if (t_last) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   pgwr_ptr #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(do_load), .load_addr(addr_in),
      .step(do_data), .page_o(page), .slot_o(slot)
   );

   pgwr_timer #(.WRITE_CYCLES(WRITE_CYCLES), .CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(t_start), .busy(busy),
      .last(t_last), .cnt(tcnt)
   );

   assign rd_slot     = tcnt[SLOT_W-1:0];
   assign commit_slot = busy && (tcnt < CNT_W'(PAGE_BYTES));

   pgwr_buf #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES), .SLOT_W(SLOT_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clear(do_clear), .wr_en(do_data),
      .wr_slot(slot), .wr_data(data_in), .rd_slot(rd_slot),
      .rd_data(mem_wdata), .rd_valid(rd_vld), .any_valid(any_vld)
   );

   if (PROTECT_UPPER) begin : g_protect
      assign protect = page[PAGE_W-1];
      // R5
      no_prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mem_we |-> !mem_addr[ADDR_W-1]);
   end else begin : g_open
      assign protect = 1'b0;
   end

   assign mem_we   = commit_slot && rd_vld && !protect;
   assign mem_addr = {page, rd_slot};

   // R3
   we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);
   // R7
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(page));
endmodule

// File: tb/pgwr_engine_tb.sv
module pgwr_engine_tb;
   localparam int WC = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_load = 1'b0, data_valid = 1'b0, stop = 1'b0, abort = 1'b0;
   logic [7:0] addr_in = '0, data_in = '0;
   logic       mem_we, busy;
   logic [7:0] mem_addr, mem_wdata;

   logic [7:0] ram [256];
   logic [7:0] expm [256];
   int n_run = 0, n_fail = 0, we_cnt = 0, we_prot = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pgwr_engine #(.WRITE_CYCLES(WC)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
      .data_valid(data_valid), .data_in(data_in), .stop(stop), .abort(abort),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) ram[i] <= 8'(i) ^ 8'hA5;
      end else if (mem_we) begin
         ram[mem_addr] <= mem_wdata;
         we_cnt <= we_cnt + 1;
         if (mem_addr[7]) we_prot <= we_prot + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cmp_mem(input string req);
      int bad = 0, first = -1;
      for (int i = 0; i < 256; i++)
         if (ram[i] !== expm[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      if (first < 0) chk(1'b1, req, 0, 0);
      else chk(1'b0, {req, " array"}, {first, 8'h0, ram[first]}, {first, 8'h0, expm[first]});
   endtask

   task automatic do_load(input logic [7:0] a);
      @(negedge clk); addr_load = 1'b1; addr_in = a;
      @(negedge clk); addr_load = 1'b0;
   endtask
   task automatic do_byte(input logic [7:0] d);
      @(negedge clk); data_valid = 1'b1; data_in = d;
      @(negedge clk); data_valid = 1'b0;
   endtask
   task automatic do_pulse_stop();
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
   endtask
   // stop then count busy cycles (sampled on falling edges)
   task automatic stop_and_wait(output int cyc);
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
      cyc = 0;
      while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
   endtask

   task automatic t_reset();
      chk(busy === 1'b0, "R9 busy", busy, 0);
      chk(mem_we === 1'b0, "R9 mem_we", mem_we, 0);
   endtask

   task automatic t_byte_write();
      int c, w0 = we_cnt;
      do_load(8'h13); do_byte(8'h5C);
      stop_and_wait(c);
      expm[8'h13] = 8'h5C;
      chk(c == WC, "R6 busy length", c, WC);
      chk(we_cnt - w0 == 1, "R4 one strobe", we_cnt - w0, 1);
      cmp_mem("R4 byte write");
   endtask

   task automatic t_full_page();
      int c;
      do_load(8'h20);
      for (int i = 0; i < 8; i++) begin do_byte(8'h30 + 8'(i)); expm[8'h20 + i] = 8'h30 + 8'(i); end
      stop_and_wait(c);
      chk(c == WC, "R6 busy length", c, WC);
      cmp_mem("R1 full page");
   endtask

   task automatic t_wrap_in_page();
      int c;
      logic [7:0] a;
      do_load(8'h2D);
      for (int i = 0; i < 5; i++) begin
         a = {5'b00101, 3'(5 + i)};
         do_byte(8'hC0 + 8'(i)); expm[a] = 8'hC0 + 8'(i);
      end
      stop_and_wait(c);
      chk(ram[8'h30] === 8'h30 ^ 8'hA5, "R1 next page untouched", ram[8'h30], 8'h30 ^ 8'hA5);
      cmp_mem("R1 slot wrap");
   endtask

   task automatic t_overflow();
      int c;
      do_load(8'h40);
      for (int i = 0; i < 10; i++) begin do_byte(8'h60 + 8'(i)); expm[8'h40 + (i % 8)] = 8'h60 + 8'(i); end
      stop_and_wait(c);
      chk(ram[8'h40] === 8'h68, "R2 overwrite", ram[8'h40], 8'h68);
      cmp_mem("R2 overflow");
   endtask

   task automatic t_no_early_write();
      int c, w0 = we_cnt;
      do_load(8'h78);
      do_byte(8'h11); do_byte(8'h22);
      repeat (4) @(negedge clk);
      chk(we_cnt == w0, "R3 no strobe before stop", we_cnt - w0, 0);
      cmp_mem("R3 array before stop");
      expm[8'h78] = 8'h11; expm[8'h79] = 8'h22;
      stop_and_wait(c);
      cmp_mem("R5 top writable page");
   endtask

   task automatic t_protected();
      int c, w0 = we_cnt;
      do_load(8'h90);
      do_byte(8'h01); do_byte(8'h02); do_byte(8'h03);
      stop_and_wait(c);
      chk(c == WC, "R10 busy on protected", c, WC);
      chk(we_cnt == w0, "R5 no strobe", we_cnt - w0, 0);
      chk(we_prot == 0, "R5 protected strobes", we_prot, 0);
      cmp_mem("R5 protected array");
   endtask

   task automatic t_abort();
      int c = 0;
      do_load(8'h08); do_byte(8'hAA); do_byte(8'hBB);
      @(negedge clk); abort = 1'b1;
      @(negedge clk); abort = 1'b0;
      repeat (3) begin if (busy) c++; @(negedge clk); end
      chk(c == 0, "R8 no busy after abort", c, 0);
      do_pulse_stop();
      repeat (3) begin if (busy) c++; @(negedge clk); end
      chk(c == 0, "R3 stop with nothing buffered", c, 0);
      cmp_mem("R8 abort");
   endtask

   task automatic t_reload();
      int c;
      do_load(8'h50); do_byte(8'h77); do_byte(8'h78);
      do_load(8'h63); do_byte(8'h99);
      expm[8'h63] = 8'h99;
      stop_and_wait(c);
      cmp_mem("R8 reload discards");
   endtask

   task automatic t_busy_ignore();
      int c = 0;
      do_load(8'h70); do_byte(8'h4E);
      expm[8'h70] = 8'h4E;
      do_pulse_stop();
      @(negedge clk); addr_load = 1'b1; addr_in = 8'h71;
      @(negedge clk); addr_load = 1'b0; data_valid = 1'b1; data_in = 8'hEE;
      @(negedge clk); data_valid = 1'b0; abort = 1'b1;
      @(negedge clk); abort = 1'b0;
      while (busy && c < 1000) begin c++; @(negedge clk); end
      do_pulse_stop();
      c = 0;
      repeat (4) begin if (busy) c++; @(negedge clk); end
      chk(c == 0, "R7 stop ignored after window", c, 0);
      cmp_mem("R7 inputs ignored while busy");
   endtask

   initial begin
      for (int i = 0; i < 256; i++) expm[i] = 8'(i) ^ 8'hA5;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_byte_write();
      t_full_page();
      t_wrap_in_page();
      t_overflow();
      t_no_early_write();
      t_protected();
      t_abort();
      t_reload();
      t_busy_ignore();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule